// File: doc/BRIEF.md
# Dual-Rail Carry Ripple Adder with Completion Flag

This block adds two operands and a carry-in. It is a cascade of two-bit slices. Inside each slice the carry into the upper bit comes from look-ahead logic. Between slices the carry ripples as a pair of complementary rails, one for true and one for false. Each slice waits for its carry-in rails before it resolves its own sum bits and its own carry-out rails. Because of this, the carry-out of the last slice is always the last signal to settle. Completion is therefore flagged by a single OR of the last slice's two rails, and no AND across all slices is needed.

The block is a synthesizable, clock-driven model of that self-timed behaviour. An evaluate/precharge input, `evalEn`, drives a four-phase handshake:

- While `evalEn` is low, the block is in precharge and every rail, every sum bit and the completion flag are cleared.
- Once `evalEn` is raised, one slice resolves per clock edge. This stands in for the carry propagation delay.
- `done` rises when the last slice resolves.
- The user samples the sum and carry while `done` is high, then drops `evalEn` to precharge before the next operation.

Top module: `dradd_top`

## Requirements
- R1: When `done` is high, `{coutTrue, sumOut}` equals `opA + opB + carryIn`, using the operands held since evaluate began.
- R2: When `done` is high, `coutTrue` is the carry-out and `coutFalse` is its complement. At no time are `coutTrue` and `coutFalse` both 1.
- R3: Precharge clears the outputs. After any clock edge at which `evalEn` is 0, `sumOut`, `coutTrue`, `coutFalse` and `done` are all 0.
- R4: Call the first rising edge with `evalEn` high, entered from precharge, edge 1. Then `done` is 0 after edges 1 to NUM_SLICES-1 and becomes 1 after edge NUM_SLICES (edge 4 by default).
- R5: While `evalEn` stays high after `done` has risen, `done`, `sumOut` and the carry rails hold their values. Changes on `opA`, `opB` and `carryIn` in that time have no effect.
- R6: If `evalEn` drops before `done` rises, the operation is abandoned and the outputs clear. The next evaluate again takes the full NUM_SLICES edges.
- R7: After reset, and before any evaluate, all outputs are 0.
- R8: Sum bits of a slice that has not yet resolved read 0. After edge 1, `sumOut[1:0]` already equals the low two bits of `opA[1:0] + opB[1:0] + carryIn`, and `sumOut[7:2]` is 0.
- R9: Inside the block, slices resolve strictly in order from slice 0 upward. No slice ever has both of its carry rails at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one slice resolves per rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| evalEn | input | 1 | 1 = evaluate, 0 = precharge |
| opA | input | WIDTH (8) | First operand |
| opB | input | WIDTH (8) | Second operand |
| carryIn | input | 1 | Carry into slice 0 |
| sumOut | output | WIDTH (8) | Single-rail sum; unresolved slices read 0 |
| coutTrue | output | 1 | True rail of the final carry-out |
| coutFalse | output | 1 | False rail of the final carry-out |
| done | output | 1 | Completion: OR of the final carry rails |

## Verification
The add is tried with four groups of patterns:

- Full-length propagate chains, such as all-ones plus one, or alternating patterns with and without carry-in. These show whether a carry really crosses every slice boundary through the rails.
- Vectors where generate and kill dominate. These separate the true rail from the false rail.
- A known worked example and random operand pairs. These cover mixed carry patterns.
- Vectors that change the operands after completion, or abort evaluation halfway. These distinguish held results from live logic, and a restarted evaluation from a continued one.

// File: rtl/dradd_pkg.sv
package dradd_pkg;

  localparam int SLICE_W_DEF    = 2;
  localparam int NUM_SLICES_DEF = 4;
  localparam int WIDTH_DEF      = SLICE_W_DEF * NUM_SLICES_DEF;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic                      clearAll;
    logic [NUM_SLICES_DEF-1:0] fire;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_HOLD = 2'd2
  } phase_t;

endpackage

// File: rtl/dradd_slice.sv
// One look-ahead slice. It resolves only once its carry-in rail pair is valid.
module dradd_slice #(
  parameter int SLICE_W = 2
) (
  input  logic [SLICE_W-1:0] opA,
  input  logic [SLICE_W-1:0] opB,
  input  logic               cinT,
  input  logic               cinF,
  output logic [SLICE_W-1:0] sum,
  output logic               coutT,
  output logic               coutF
);

  logic               cinValid;
  logic [SLICE_W:0]   carry;
  logic [SLICE_W-1:0] genBit;
  logic [SLICE_W-1:0] propBit;
  logic [SLICE_W-1:0] rawSum;

  assign cinValid = cinT | cinF;
  assign genBit   = opA & opB;
  assign propBit  = opA ^ opB;

  // Internal carries: generate, or propagate of the lower carry.
  always_comb begin
    carry[0] = cinT;
    for (int i = 0; i < SLICE_W; i++) begin
      carry[i+1] = genBit[i] | (propBit[i] & carry[i]);
      rawSum[i]  = propBit[i] ^ carry[i];
    end
  end

  assign sum   = cinValid ? rawSum : '0;
  assign coutT = cinValid &  carry[SLICE_W];
  assign coutF = cinValid & ~carry[SLICE_W];

endmodule

// File: rtl/dradd_ctrl.sv
// Phase control: accepts evaluate, steps one slice per clock, holds, precharges.
module dradd_ctrl
  import dradd_pkg::*;
#(
  parameter int NUM_SLICES = NUM_SLICES_DEF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        evalEn,
  output ctrlStrobe_t strobe
);

  localparam int STEP_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;

  phase_t            phase, phaseNext;
  logic [STEP_W-1:0] step, stepNext;

  always_comb begin
    strobe    = '0;
    phaseNext = phase;
    stepNext  = step;
    unique case (phase)
      PH_IDLE: begin
        if (evalEn) begin
          strobe.fire = NUM_SLICES'(1);
          if (NUM_SLICES == 1) begin
            phaseNext = PH_HOLD;
          end else begin
            phaseNext = PH_RUN;
            stepNext  = STEP_W'(1);
          end
        end else begin
          strobe.clearAll = 1'b1;
        end
      end
      PH_RUN: begin
        if (evalEn) begin
          strobe.fire = NUM_SLICES'(1) << step;
          if (step == STEP_W'(NUM_SLICES - 1)) begin
            phaseNext = PH_HOLD;
            stepNext  = '0;
          end else begin
            stepNext = step + STEP_W'(1);
          end
        end else begin
          strobe.clearAll = 1'b1;
          phaseNext       = PH_IDLE;
          stepNext        = '0;
        end
      end
      PH_HOLD: begin
        if (!evalEn) begin
          strobe.clearAll = 1'b1;
          phaseNext       = PH_IDLE;
        end
      end
      default: begin
        strobe.clearAll = 1'b1;
        phaseNext       = PH_IDLE;
        stepNext        = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      step  <= '0;
    end else begin
      phase <= phaseNext;
      step  <= stepNext;
    end
  end

endmodule

// File: rtl/dradd_datapath.sv
// Slice chain with registered rails and sums. Each slice latches on its fire strobe.
module dradd_datapath
  import dradd_pkg::*;
#(
  parameter int SLICE_W    = SLICE_W_DEF,
  parameter int NUM_SLICES = NUM_SLICES_DEF,
  parameter int WIDTH      = SLICE_W * NUM_SLICES
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [WIDTH-1:0]      opA,
  input  logic [WIDTH-1:0]      opB,
  input  logic                  carryIn,
  output logic [WIDTH-1:0]      sumOut,
  output logic [NUM_SLICES-1:0] railT,
  output logic [NUM_SLICES-1:0] railF
);

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    logic               inT, inF;
    logic [SLICE_W-1:0] sliceSum;
    logic               outT, outF;
    logic [SLICE_W-1:0] sumReg;

    if (k == 0) begin : g_head
      assign inT = carryIn;
      assign inF = ~carryIn;
    end else begin : g_link
      assign inT = railT[k-1];
      assign inF = railF[k-1];
    end

    dradd_slice #(.SLICE_W(SLICE_W)) u_slice (
      .opA   (opA[k*SLICE_W +: SLICE_W]),
      .opB   (opB[k*SLICE_W +: SLICE_W]),
      .cinT  (inT),
      .cinF  (inF),
      .sum   (sliceSum),
      .coutT (outT),
      .coutF (outF)
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sumReg   <= '0;
        railT[k] <= 1'b0;
        railF[k] <= 1'b0;
      end else if (strobe.clearAll) begin
        sumReg   <= '0;
        railT[k] <= 1'b0;
        railF[k] <= 1'b0;
      end else if (strobe.fire[k]) begin
        sumReg   <= sliceSum;
        railT[k] <= outT;
        railF[k] <= outF;
      end
    end

    assign sumOut[k*SLICE_W +: SLICE_W] = sumReg;
  end

endmodule

// File: rtl/dradd_top.sv
module dradd_top
  import dradd_pkg::*;
#(
  parameter int SLICE_W    = SLICE_W_DEF,
  parameter int NUM_SLICES = NUM_SLICES_DEF,
  parameter int WIDTH      = SLICE_W * NUM_SLICES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evalEn,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             coutTrue,
  output logic             coutFalse,
  output logic             done
);

  ctrlStrobe_t           strobe;
  logic [NUM_SLICES-1:0] railT;
  logic [NUM_SLICES-1:0] railF;

  dradd_ctrl #(.NUM_SLICES(NUM_SLICES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .evalEn (evalEn),
    .strobe (strobe)
  );

  dradd_datapath #(
    .SLICE_W    (SLICE_W),
    .NUM_SLICES (NUM_SLICES),
    .WIDTH      (WIDTH)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .sumOut  (sumOut),
    .railT   (railT),
    .railF   (railF)
  );

  assign coutTrue  = railT[NUM_SLICES-1];
  assign coutFalse = railF[NUM_SLICES-1];
  assign done      = coutTrue | coutFalse;

endmodule

// File: rtl/dradd_checker.sv
module dradd_checker #(
  parameter int WIDTH      = 8,
  parameter int NUM_SLICES = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  evalEn,
  input logic [WIDTH-1:0]      sumOut,
  input logic                  coutTrue,
  input logic                  coutFalse,
  input logic                  done,
  input logic [NUM_SLICES-1:0] railT,
  input logic [NUM_SLICES-1:0] railF
);

  localparam int CNT_W = $clog2(NUM_SLICES + 1);

  logic [CNT_W-1:0]      evalCnt;
  logic [NUM_SLICES-1:0] validVec;

  assign validVec = railT | railF;

  // Counts edges with evaluate held, saturating at the slice count.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               evalCnt <= '0;
    else if (!evalEn)                        evalCnt <= '0;
    else if (evalCnt != CNT_W'(NUM_SLICES))  evalCnt <= evalCnt + CNT_W'(1);
  end

  p_rails_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(coutTrue && coutFalse));

  p_precharge_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    !evalEn |=> (!done && !coutTrue && !coutFalse && sumOut == '0));

  p_done_latency_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> evalCnt == CNT_W'(NUM_SLICES));

  p_done_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && evalEn) |=> (done && $stable(sumOut) && $stable(coutTrue)));

  p_slice_order_r9: assert property (@(posedge clk) disable iff (!rstN)
    (validVec & (validVec + NUM_SLICES'(1))) == '0);

  p_slice_rails_r9: assert property (@(posedge clk) disable iff (!rstN)
    (railT & railF) == '0);

endmodule

bind dradd_top dradd_checker #(.WIDTH(WIDTH), .NUM_SLICES(NUM_SLICES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .evalEn    (evalEn),
  .sumOut    (sumOut),
  .coutTrue  (coutTrue),
  .coutFalse (coutFalse),
  .done      (done),
  .railT     (railT),
  .railF     (railF)
);

// File: tb/tb_dradd_top.sv
module tb_dradd_top;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int NS         = 4;
  localparam int NVEC       = 10;

  // Each entry is {a[7:0], b[7:0], cin, expected {carry, sum}[8:0]}.
  localparam logic [25:0] VEC [NVEC] = '{
    {8'hC9, 8'h5D, 1'b1, 9'h127},
    {8'hFF, 8'h00, 1'b1, 9'h100},
    {8'hFF, 8'h01, 1'b0, 9'h100},
    {8'h00, 8'h00, 1'b0, 9'h000},
    {8'hAA, 8'h55, 1'b0, 9'h0FF},
    {8'hAA, 8'h55, 1'b1, 9'h100},
    {8'h80, 8'h80, 1'b0, 9'h100},
    {8'h0F, 8'hF1, 1'b0, 9'h100},
    {8'h7F, 8'h7F, 1'b1, 9'h0FF},
    {8'hFF, 8'hFF, 1'b1, 9'h1FF}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         evalEn = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] sumOut;
  logic         coutTrue, coutFalse, done;

  int total = 0;
  int bad   = 0;

  dradd_top dut (
    .clk       (clk),
    .rstN      (rstN),
    .evalEn    (evalEn),
    .opA       (opA),
    .opB       (opB),
    .carryIn   (carryIn),
    .sumOut    (sumOut),
    .coutTrue  (coutTrue),
    .coutFalse (coutFalse),
    .done      (done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Outputs are sampled 1 time unit after a rising edge.
  task automatic edgeWait();
    @(posedge clk);
    #1;
  endtask

  task automatic precharge();
    @(negedge clk);
    evalEn = 1'b0;
    edgeWait();
    chk("R3 precharge", {sumOut, coutTrue, coutFalse, done}, 32'h0);
  endtask

  task automatic runAdd(input logic [7:0] a, input logic [7:0] b, input logic c,
                        input logic [8:0] exp, input bit holdCheck);
    logic [1:0] lowExp;
    lowExp = 2'(a[1:0] + b[1:0] + c);
    @(negedge clk);
    opA = a; opB = b; carryIn = c; evalEn = 1'b1;
    for (int k = 1; k <= NS; k++) begin
      edgeWait();
      if (k < NS) chk("R4 done low before last slice", done, 1'b0);
      else        chk("R4 done after last slice", done, 1'b1);
      if (k == 1) chk("R8 partial sum after edge 1", sumOut, {6'b0, lowExp});
    end
    chk("R1 sum and carry", {coutTrue, sumOut}, exp);
    chk("R2 dual rails", {coutTrue, coutFalse}, {exp[8], ~exp[8]});
    if (holdCheck) begin
      @(negedge clk);
      opA = ~a; opB = a ^ 8'h3C; carryIn = ~c;
      edgeWait();
      edgeWait();
      chk("R5 held result", {done, coutTrue, sumOut}, {1'b1, exp});
    end
    precharge();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3;
    // R7: outputs are 0 while reset is held and just after it is released
    chk("R7 reset state", {sumOut, coutTrue, coutFalse, done}, 32'h0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    edgeWait();
    chk("R7 after reset", {sumOut, coutTrue, coutFalse, done}, 32'h0);

    // Table walk; the first entry is the worked example
    for (int i = 0; i < NVEC; i++) begin
      runAdd(VEC[i][25:18], VEC[i][17:10], VEC[i][9], VEC[i][8:0], (i % 3) == 0);
    end

    // R6: abandon the evaluation halfway
    @(negedge clk);
    opA = 8'hFF; opB = 8'h00; carryIn = 1'b1; evalEn = 1'b1;
    edgeWait();
    edgeWait();
    @(negedge clk);
    evalEn = 1'b0;
    edgeWait();
    chk("R6 abort clears", {sumOut, coutTrue, coutFalse, done}, 32'h0);
    runAdd(8'h01, 8'hFF, 1'b0, 9'h100, 1'b0);  // R6: full latency again after the abort

    // Random vectors with independently computed expected values
    for (int j = 0; j < 40; j++) begin
      logic [7:0] ra, rb;
      logic       rc;
      ra = 8'($urandom);
      rb = 8'($urandom);
      rc = 1'($urandom);
      runAdd(ra, rb, rc, 9'(ra) + 9'(rb) + 9'(rc), (j % 8) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule